// File: doc/BRIEF.md
# Two-Level Four-Way Arbiter with Winner Token

This block lets four requesters share one resource. It is built as a tree of two-way arbiters. Two leaf arbiters each decide between a pair of requesters and produce a one-bit token that names the local winner. Each leaf also raises an upward request whenever either of its inputs is active. A root arbiter decides between those two upward requests. The final two-bit winner index puts the root's choice in the upper bit and the chosen leaf's token in the lower bit.

Once a grant is issued, it stays on the winning line until the resource owner pulses release. Arbitration is paused for that whole time. The winning channel is therefore not freed until the resource is free.

The interface works as a request/grant handshake, which acts as back-pressure. A requester keeps its request high until its grant bit rises. The arbiter never stores a request. A request that is dropped before it is granted is lost, and its requester is held back until a later round grants it.

Top module: `arb4_tree`

## Requirements
- R1: After reset, `grant` is 0, `win_vld` is 0, and every arbiter favours its lower input.
- R2: When the block is idle, a sampled request leads to a grant on the next clock edge. The granted bit is always one whose request was high at that edge.
- R3: At most one `grant` bit is high. While `win_vld` is high, `grant` is the one-hot decode of `win_idx`; otherwise `grant` is 0.
- R4: While `win_vld` is high and `release_i` is low, `grant` and `win_idx` keep their values, whatever happens on `req`.
- R5: When `release_i` is sampled high during a grant, `grant` and `win_vld` are 0 on the following cycle. That cycle is always free of any grant.
- R6: Each leaf handles requesters 2k and 2k+1. When both are active, the leaf picks the input it favours. After such a contested pick is granted, the leaf favours the other input. Uncontested picks leave the preference unchanged.
- R7: The root decides between leaf 0 (requesters 0 and 1) and leaf 1 (requesters 2 and 3). It alternates in the same way after contested rounds.
- R8: Bit 1 of `win_idx` names the leaf that won, and bit 0 is that leaf's token. Only the arbiters on the winning path update their preference.
- R9: A `release_i` pulse while idle has no effect. With no request, no grant appears.
- R10: A request that rises and falls during someone else's grant is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 4 | Request lines, bit i belongs to requester i |
| release_i | input | 1 | Resource free pulse that ends the current grant |
| grant | output | 4 | One-hot grant, held until release |
| win_vld | output | 1 | Winner token valid, high from grant until release |
| win_idx | output | 2 | Winner token: {leaf, leaf token} |

## Verification
The bench sends all four requests at once, which shows whether the root and both leaves are rotated and whether a losing leaf keeps its preference. It then sends cross-pair pairs (1 and 2), which separate root fairness from leaf fairness. Same-pair pairs (0/1, then 2/3) check each leaf on its own, and single requests check that an uncontested round leaves every preference as it was. Directed tests cover the reset state, holding the grant under changing requests, the idle cycle after release, release while idle, and a request withdrawn before it could win.

// File: rtl/arb4_pkg.sv
package arb4_pkg;
  localparam int unsigned N_REQ    = 4;
  localparam int unsigned N_LEAF   = N_REQ / 2;
  localparam int unsigned IDX_W    = $clog2(N_REQ);
  localparam int unsigned LEAF_W   = $clog2(N_LEAF);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_e;
endpackage

// File: rtl/pair_arb.sv
// Two-way arbiter: one-bit token, upward request, rotating preference.
module pair_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic in0,
  input  logic in1,
  input  logic commit,
  output logic token,
  output logic up
);
  logic fav;      // 0: favour in0, 1: favour in1
  logic contest;

  assign contest = in0 & in1;
  assign up      = in0 | in1;

  always_comb begin
    if (contest) token = fav;
    else         token = in1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fav <= 1'b0;
    else if (commit && contest) fav <= ~token;
  end
endmodule

// File: rtl/grant_hold.sv
// Holds the winner token from the grant until the resource is released.
module grant_hold
  import arb4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] next_idx,
  input  logic             rel,
  output logic             busy,
  output logic [IDX_W-1:0] idx
);
  hold_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st  <= ST_HOLD;
          idx <= next_idx;
        end
        ST_HOLD: if (rel) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy = (st == ST_HOLD);
endmodule

// File: rtl/arb4_tree.sv
module arb4_tree
  import arb4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             release_i,
  output logic [N_REQ-1:0] grant,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx
);
  logic [N_LEAF-1:0] leaf_tok;
  logic [N_LEAF-1:0] leaf_up;
  logic              root_tok;
  logic              root_up;
  logic              start;
  logic              busy;
  logic [IDX_W-1:0]  pick;

  assign start = ~busy & root_up;

  generate
    for (genvar k = 0; k < N_LEAF; k++) begin : g_leaf
      pair_arb i_leaf (
        .clk    (clk),
        .rst_n  (rst_n),
        .in0    (req[2*k]),
        .in1    (req[2*k+1]),
        .commit (start && (root_tok == LEAF_W'(k))),
        .token  (leaf_tok[k]),
        .up     (leaf_up[k])
      );
    end
  endgenerate

  pair_arb i_root (
    .clk    (clk),
    .rst_n  (rst_n),
    .in0    (leaf_up[0]),
    .in1    (leaf_up[1]),
    .commit (start),
    .token  (root_tok),
    .up     (root_up)
  );

  assign pick = {root_tok, leaf_tok[root_tok]};

  grant_hold i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .next_idx (pick),
    .rel      (release_i),
    .busy     (busy),
    .idx      (win_idx)
  );

  assign win_vld = busy;

  always_comb begin
    for (int i = 0; i < N_REQ; i++)
      grant[i] = busy && (win_idx == IDX_W'(i));
  end
endmodule

// File: rtl/arb4_tree_chk.sv
module arb4_tree_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] req,
  input logic       release_i,
  input logic [3:0] grant,
  input logic       win_vld,
  input logic [1:0] win_idx
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r3_token_match: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> grant[win_idx]);
  a_r2_granted_had_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_vld) |-> (($past(req) & grant) != 4'd0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && !release_i) |=> (win_vld && $stable(grant) && $stable(win_idx)));
  a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && release_i) |=> (!win_vld && grant == 4'd0));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_vld && req == 4'd0) |=> !win_vld);
endmodule

bind arb4_tree arb4_tree_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .release_i(release_i),
  .grant(grant), .win_vld(win_vld), .win_idx(win_idx)
);

// File: tb/test_arb4_tree.sv
module test_arb4_tree;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = 4'd0;
  logic       release_i = 1'b0;
  logic [3:0] grant;
  logic       win_vld;
  logic [1:0] win_idx;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  arb4_tree i_arb4_tree (
    .clk(clk), .rst_n(rst_n), .req(req), .release_i(release_i),
    .grant(grant), .win_vld(win_vld), .win_idx(win_idx)
  );

  // {req, expected winner}: sequence from reset, rotation per R6/R7/R8
  localparam logic [5:0] VEC [0:11] = '{
    {4'hF, 2'd0}, {4'hF, 2'd2}, {4'hF, 2'd1}, {4'hF, 2'd3},
    {4'h1, 2'd0}, {4'h8, 2'd3}, {4'h6, 2'd1}, {4'h6, 2'd2},
    {4'h3, 2'd0}, {4'h3, 2'd1}, {4'hC, 2'd2}, {4'hC, 2'd3}
  };

  task automatic chk(input string rq, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {vld,idx,grant}=%b expected %b", rq, act, exp);
    end
  endtask

  function automatic logic [6:0] busy_val(input logic [1:0] w);
    return {1'b1, w, 4'b0001 << w};
  endfunction

  task automatic drop_grant();
    req = 4'd0; release_i = 1'b1;
    @(posedge clk); @(negedge clk);
    release_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {win_vld, win_idx, grant}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {win_vld, win_idx, grant}, 7'd0);

    for (int i = 0; i < 12; i++) begin
      req = VEC[i][5:2];
      @(posedge clk); @(negedge clk);
      chk($sformatf("R6 R7 R8 R2 R3 vector %0d", i),
          {win_vld, win_idx, grant}, busy_val(VEC[i][1:0]));
      drop_grant();
      chk("R5 free cycle after release", {win_vld, grant}, 5'd0);
    end

    // R4: hold under changing requests
    req = 4'h2;
    @(posedge clk); @(negedge clk);
    chk("R2 single request", {win_vld, win_idx, grant}, busy_val(2'd1));
    req = 4'hD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 grant held", {win_vld, win_idx, grant}, busy_val(2'd1));
    // R10: requester 3 withdraws before release
    req = 4'h8;
    @(posedge clk); @(negedge clk);
    req = 4'h0;
    chk("R4 still held", {win_vld, win_idx, grant}, busy_val(2'd1));
    drop_grant();
    chk("R5 drop after release", {win_vld, grant}, 5'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 withdrawn request not granted", {win_vld, grant}, 5'd0);

    // R9: release while idle
    release_i = 1'b1;
    @(posedge clk); @(negedge clk);
    release_i = 1'b0;
    chk("R9 idle release ignored", {win_vld, grant}, 5'd0);
    req = 4'h4;
    @(posedge clk); @(negedge clk);
    chk("R9 next grant normal", {win_vld, win_idx, grant}, busy_val(2'd2));
    drop_grant();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule